// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Interface

This block gathers thirty-two interrupt request lines into one interrupt output for a processor. Each line is built either as a level-type source or as a rising-edge source, chosen by one bit of a build-time mask. When hardware sampling is on, a source that fires sets its bit in a status register. The status register is ANDed with an enable register to form the pending set. A priority encoder reports the lowest-numbered pending source as a vector, and the output is raised when output gating is on and anything is pending.

Software reaches the block through a word-indexed register port. A write is one cycle with `wr_en` high, and reads are combinational from `reg_idx`. Software can acknowledge sources by writing ones, and can set or clear enable bits without a read-modify-write. Until hardware sampling is switched on, software can also load the status register directly, which lets it inject interrupts.

The two master bits are held as a four-state mode machine with these states:
- `MODE_OFF`: no output gating and no sampling.
- `MODE_OUT`: output gating only.
- `MODE_SAMPLE`: sampling only.
- `MODE_FULL`: both.

Every write to the master register moves the machine straight to the state coded by write-data bits 1:0. No other event changes the state.

Top module: `vic_top`

## Requirements
- R1: The pending register (index 1, byte offset 0x04) always reads as status AND enable.
- R2: The vector register (index 6, offset 0x18) reads the index of the lowest-numbered set pending bit, so bit 0 has the highest priority. It reads 0xFFFFFFFF when nothing is pending.
- R3: `irq_out` is high exactly when master bit 0 is set and at least one pending bit is set.
- R4: A write to the master register (index 7, offset 0x1C) keeps only write-data bits 1:0. Bit 0 gates the output and bit 1 enables hardware sampling, and bits 31:2 read as zero.
- R5: A write to the acknowledge location (index 3, offset 0x0C) clears each status bit whose write-data bit is 1 and leaves the other status bits alone.
- R6: A write to the enable register (index 2, offset 0x08) replaces it. A write to set-enable (index 4, offset 0x10) ORs the data into it, and a write to clear-enable (index 5, offset 0x14) clears the bits written as 1.
- R7: While sampling is on, a level-type input that is high sets its status bit. The bit comes back after an acknowledge for as long as the input stays high.
- R8: While sampling is on, an edge-type input sets its status bit only on a low-to-high transition. An acknowledge while the input stays high leaves the bit clear.
- R9: A write to the status register (index 0, offset 0x00) replaces it only while sampling is off. While sampling is on, the write is ignored.
- R10: While sampling is off, input changes leave the status register unchanged.
- R11: The acknowledge, set-enable and clear-enable locations read as zero. Writes to the pending and vector registers have no effect.
- R12: Reset clears status, enable, master bits and the input history. After reset, the vector reads 0xFFFFFFFF and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Interrupt request lines, synchronised inside the block |
| wr_en | input | 1 | Write strobe, one write per cycle high |
| reg_idx | input | 3 | Word index of the register (byte address bits 4:2) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from `reg_idx` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted status or enable bit shows up at once, in the same cycle, on the pending and vector reads. If the bit is enabled and output gating is on, it also shows on `irq_out`. A wrong mode state shows on the master read right away. It shows in the status register one cycle later, either because sampled inputs fail to land there or because an injected write is accepted when it should be ignored. A fault in the input history, such as a missed or doubled edge, shows three cycles after the input moves. The bench compares every readable register and `irq_out` after each operation, so any such fault is caught within that operation.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [2:0] {
        A_STATUS  = 3'd0,
        A_PENDING = 3'd1,
        A_ENABLE  = 3'd2,
        A_ACK     = 3'd3,
        A_SETEN   = 3'd4,
        A_CLREN   = 3'd5,
        A_VECTOR  = 3'd6,
        A_MODE    = 3'd7
    } reg_sel_e;

    // bit 0 = output gating, bit 1 = hardware sampling
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_OUT    = 2'b01,
        MODE_SAMPLE = 2'b10,
        MODE_FULL   = 2'b11
    } mode_e;

endpackage

// File: rtl/vic_insync.sv
module vic_insync #(
    parameter int N_SRC = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             smp_en,
    output logic [N_SRC-1:0] hw_set
);

    logic [N_SRC-1:0] meta_q;
    logic [N_SRC-1:0] sync_q;
    logic [N_SRC-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= irq_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (EDGE_MASK[g]) begin : g_edge
            assign hw_set[g] = smp_en & sync_q[g] & ~hist_q[g];
        end else begin : g_level
            assign hw_set[g] = smp_en & sync_q[g];
        end
    end

    // R8
    edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & EDGE_MASK)) |=> ((hw_set & $past(hw_set) & EDGE_MASK) == '0));

    // R10
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |-> (hw_set == '0));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 32,
    localparam int IW = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pending,
    output logic             found,
    output logic [IW-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R2
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (pending[idx] &&
                   ((pending & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0)));

    // R2
    none_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (pending == '0));

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       reg_idx,
    input  logic [DW-1:0]    wdata,
    input  logic [N_SRC-1:0] hw_set,
    input  logic             vec_found,
    input  logic [IW-1:0]    vec_idx,
    output logic [N_SRC-1:0] pending,
    output logic             out_en,
    output logic             smp_en,
    output logic [DW-1:0]    rdata
);

    reg_sel_e         sel;
    mode_e            state_q, state_d;
    logic [N_SRC-1:0] status_q, status_d;
    logic [N_SRC-1:0] enable_q, enable_d;
    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] ack_mask;
    logic             stat_wr;

    assign sel   = reg_sel_e'(reg_idx);
    assign wmask = wdata[N_SRC-1:0];

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en && sel == A_MODE) begin
            unique case (wdata[1:0])
                2'b00:   state_d = MODE_OFF;
                2'b01:   state_d = MODE_OUT;
                2'b10:   state_d = MODE_SAMPLE;
                default: state_d = MODE_FULL;
            endcase
        end
    end

    // mode outputs
    always_comb begin
        unique case (state_q)
            MODE_OFF:    begin out_en = 1'b0; smp_en = 1'b0; end
            MODE_OUT:    begin out_en = 1'b1; smp_en = 1'b0; end
            MODE_SAMPLE: begin out_en = 1'b0; smp_en = 1'b1; end
            default:     begin out_en = 1'b1; smp_en = 1'b1; end
        endcase
    end

    // status and enable
    always_comb begin
        stat_wr  = wr_en && sel == A_STATUS && !smp_en;
        ack_mask = (wr_en && sel == A_ACK) ? wmask : '0;
        status_d = ((stat_wr ? wmask : status_q) & ~ack_mask) | hw_set;

        enable_d = enable_q;
        if (wr_en) begin
            unique case (sel)
                A_ENABLE: enable_d = wmask;
                A_SETEN:  enable_d = enable_q | wmask;
                A_CLREN:  enable_d = enable_q & ~wmask;
                default:  enable_d = enable_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign pending = status_q & enable_q;

    always_comb begin
        unique case (sel)
            A_STATUS:  rdata = DW'(status_q);
            A_PENDING: rdata = DW'(pending);
            A_ENABLE:  rdata = DW'(enable_q);
            A_VECTOR:  rdata = vec_found ? DW'(vec_idx) : '1;
            A_MODE:    rdata = DW'(state_q);
            default:   rdata = '0;
        endcase
    end

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_ACK && !smp_en) |=> ((status_q & $past(wmask)) == '0));

    // R6
    seten_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_SETEN) |=> ((enable_q & $past(wmask)) == $past(wmask)));

    // R6
    clren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_CLREN) |=> ((enable_q & $past(wmask)) == '0));

    // R7
    hw_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((status_q & $past(hw_set)) == $past(hw_set)));

    // R9
    locked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == A_STATUS && smp_en) |=>
            (status_q == ($past(status_q) | $past(hw_set))));

    // R10
    quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !wr_en) |=> $stable(status_q));

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int N_SRC = 32,
    parameter int DW    = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             wr_en,
    input  logic [2:0]       reg_idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_out
);

    localparam int IW = $clog2(N_SRC);

    logic [N_SRC-1:0] hw_set;
    logic [N_SRC-1:0] pending;
    logic             smp_en;
    logic             out_en;
    logic             vec_found;
    logic [IW-1:0]    vec_idx;

    vic_insync #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .smp_en (smp_en),
        .hw_set (hw_set)
    );

    vic_regfile #(.N_SRC(N_SRC), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .reg_idx   (reg_idx),
        .wdata     (wdata),
        .hw_set    (hw_set),
        .vec_found (vec_found),
        .vec_idx   (vec_idx),
        .pending   (pending),
        .out_en    (out_en),
        .smp_en    (smp_en),
        .rdata     (rdata)
    );

    vic_prio #(.N_SRC(N_SRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .found   (vec_found),
        .idx     (vec_idx)
    );

    assign irq_out = out_en & vec_found;

    // R3
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pending != '0));

endmodule

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;

    localparam logic [31:0] TB_EDGE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_status = '0;
    logic [31:0] m_enable = '0;
    logic [1:0]  m_mode = '0;
    logic [31:0] m_pins = '0;

    always #4 clk = ~clk;

    vic_top #(.N_SRC(32), .DW(32), .EDGE_MASK(TB_EDGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .reg_idx(reg_idx), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_vec(input logic [31:0] p);
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_reg(input int idx);
        logic [31:0] p = m_status & m_enable;
        case (idx)
            0: return m_status;
            1: return p;
            2: return m_enable;
            6: return exp_vec(p);
            7: return {30'b0, m_mode};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        reg_idx = 3'(idx);
        #1 v = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        string tags [8] = '{"R9 status", "R1 pending", "R6 enable", "R11 ack",
                            "R11 seten", "R11 clren", "R2 vector", "R4 master"};
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            check({tag, " ", tags[i]}, v, exp_reg(i));
        end
        check({tag, " R3 irq_out"}, {31'b0, irq_out},
              {31'b0, m_mode[0] && ((m_status & m_enable) != 0)});
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = 3'(idx); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        case (idx)
            0: if (!m_mode[1]) m_status = d;
            2: m_enable = d;
            3: m_status &= ~d;
            4: m_enable |= d;
            5: m_enable &= ~d;
            7: m_mode = d[1:0];
            default: ;
        endcase
        if (m_mode[1]) m_status |= m_pins & ~TB_EDGE;
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (5) @(negedge clk);
        if (m_mode[1]) m_status |= (v & ~TB_EDGE) | (v & ~m_pins & TB_EDGE);
        m_pins = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R12 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12 reset");
        rd(6, v); check("R12 vector after reset", v, 32'hFFFF_FFFF);

        // injection while sampling is off
        wr(0, 32'h0000_0005); check_all("R9 inject");
        wr(2, 32'h0000_0004); check_all("R1 enable");
        wr(7, 32'hFFFF_FFFD); check_all("R4 master");
        wr(4, 32'h0000_0001); check_all("R6 seten");
        wr(5, 32'h0000_0004); check_all("R6 clren");
        wr(1, 32'hFFFF_FFFF); check_all("R11 pending write");
        wr(6, 32'h0000_0000); check_all("R11 vector write");
        wr(3, 32'h0000_0001); check_all("R5 ack");
        pins(32'h0000_0003);  check_all("R10 inputs ignored");
        wr(2, 32'hFFFF_FFFF);
        wr(7, 32'h0000_0003); check_all("R7 level sampled");
        wr(3, 32'h0000_0003); check_all("R7 level after ack");
        wr(0, 32'h0000_0000); check_all("R9 locked write");
        pins(32'h0000_0000);
        wr(3, 32'hFFFF_FFFF); check_all("R5 ack all");
        pins(32'h0001_0000);  check_all("R8 edge rise");
        wr(3, 32'h0001_0000); check_all("R8 ack while high");
        pins(32'h0000_0000);  check_all("R8 fall");
        pins(32'h0001_0000);  check_all("R8 second rise");
        wr(3, 32'hFFFF_FFFF);
        pins(32'h8000_8000);  check_all("R2 mixed sources");

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 9) < 7) begin
                int idx = $urandom_range(0, 7);
                wr(idx, $urandom());
            end else begin
                pins($urandom() & $urandom());
            end
            check_all("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule